// File: doc/BRIEF.md
# DDR SDRAM Command Decoder and Bank Monitor

This block watches the control pins of a DDR SDRAM interface on every rising clock edge and turns each sampled pin pattern into a single registered command code. The pins it samples are the clock enable for the previous and current cycle, chip select, the row strobe, the column strobe, write enable, the bank-select bits and the auto-precharge address bit. Pin patterns that no legal command uses are reported as illegal. The block also reports a clock enable whose level did not hold for a whole cycle.

Alongside the decode, the block keeps a model of the memory. For each bank it records whether the bank is open or closed. It records whether a read or write burst is in progress and when that burst will end. It applies a deferred precharge once an auto-precharge burst completes. Commands that break the protocol raise a one-cycle error strobe, and the model is left unchanged by them. An activate to an open bank and a column access to a closed bank also set a sticky flag for the bank concerned. The burst length comes from a static select input.

The block is purely an observer. It has no data path and drives nothing back to the memory, so it has no flow control. All inputs and outputs are plain level signals sampled or updated on the rising clock edge.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: While reset is held and on the first cycle after it, the outputs read: cmd_o = 0 (deselect), bank_active_o = 0, busy_o = 0, busy_wr_o = 0, err_o = 0, bank_err_o = 0.
- R2: With cs_n_i high and a consistent clock enable, cmd_o becomes 0 (deselect) after the edge and err_o stays low. All other pins are ignored, and the bank vector and sticky flags keep their values.
- R3: With cs_n_i low and both clock-enable samples high, the {ras_n_i, cas_n_i, we_n_i} patterns decode as follows:
  - 111 gives NOP (1).
  - 110 gives burst stop (2).
  - 101 gives read (3 or 4).
  - 100 gives write (5 or 6).
  - 011 gives activate (7).
  - 010 gives precharge (8 or 9).
  - 001 gives refresh (10).
  - 000 gives mode-register set (12 or 13).

  cmd_o shows the code one clock after the edge at which the pins were sampled. bank_o shows ba_i from every non-deselect command.
- R4: ap_i selects the command variant:
  - For reads, ap_i low gives read (3) and ap_i high gives read with auto-precharge (4).
  - For writes, ap_i low gives write (5) and ap_i high gives write with auto-precharge (6).
  - For precharge, ap_i low gives single-bank precharge (8), which closes only bank ba_i. ap_i high gives precharge-all (9), which closes every bank whatever ba_i is.
- R5: Pattern 000 decodes as mode-register set (12) when ba_i = 00 and ap_i = 0. It decodes as extended mode-register set (13) when ba_i = 01 and ap_i = 0. Any other bank or ap_i value gives illegal (15) with err_o.
- R6: Pattern 001 is auto-refresh (10) when cke_prev_i and cke_cur_i are both high. It is self-refresh entry (11) when cke_prev_i is high and cke_cur_i is low.
- R7: Two cases decode as illegal (15) and raise err_o:
  - cs_n_i low while cke_prev_i is low.
  - cs_n_i low while cke_cur_i is low, with any pattern other than 001.
- R8: cke_prev_i must equal the cke_cur_i value sampled on the preceding edge, or 1 right after reset. If it differs, the clock enable did not hold for a whole cycle. The command then decodes as illegal (15), raises err_o, and changes no state.
- R9: An activate sets the bank_active_o bit of bank ba_i. A single-bank precharge or a precharge-all clears the bits that R4 names.
- R10: Two commands are rejected with err_o, leave all state unchanged, and set the bank_err_o bit of ba_i:
  - An activate to a bank that is already open.
  - A read or write to a closed bank.

  bank_err_o bits stay set until reset.
- R11: A read or write to an open bank while no burst runs starts a burst. bl_sel_i selects the length: 00 = 2 beats, 01 = 4 beats, 10 or 11 = 8 beats. busy_o is high for beats/2 cycles after the command edge. busy_wr_o is high alongside busy_o for a write. A read or write issued while busy_o is high raises err_o and is ignored.
- R12: For an auto-precharge burst, the addressed bank's bank_active_o bit clears on the same edge at which busy_o falls.
- R13: Burst stop ends a running read at that edge and applies any pending auto-precharge. During a write burst it raises err_o, and the write continues to its normal end. With no burst running it does nothing and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory command clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke_prev_i | input | 1 | Clock-enable level in the previous cycle |
| cke_cur_i | input | 1 | Clock-enable level in the current cycle |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank select |
| ap_i | input | 1 | Auto-precharge / all-bank address bit |
| bl_sel_i | input | 2 | Static burst length select |
| cmd_o | output | 4 | Registered command code |
| bank_o | output | 2 | Bank of the last non-deselect command |
| bank_active_o | output | 4 | Per-bank open flag |
| busy_o | output | 1 | Burst in progress |
| busy_wr_o | output | 1 | Running burst is a write |
| err_o | output | 1 | One-cycle protocol error strobe |
| bank_err_o | output | 4 | Sticky per-bank sequencing error |

## Verification
The properties assume the pins are stable around each rising edge. They also assume bl_sel_i changes only while no burst runs, because the burst window is loaded from it at the command edge. The stimulus drives every pin at the falling edge. It changes the burst select only between bursts, after a reset. It keeps the clock-enable pair self-consistent except in the cases that deliberately test R7 and R8. Burst stop and new column commands during a burst are issued only with clock enable held high, so the error properties see the intended cause.

// File: rtl/ddr_mon_pkg.sv
package ddr_mon_pkg;

  localparam int MAX_BEATS = 8;

  typedef enum logic [3:0] {
    CMD_DESEL   = 4'd0,
    CMD_NOP     = 4'd1,
    CMD_BSTOP   = 4'd2,
    CMD_RD      = 4'd3,
    CMD_RDA     = 4'd4,
    CMD_WR      = 4'd5,
    CMD_WRA     = 4'd6,
    CMD_ACT     = 4'd7,
    CMD_PRE     = 4'd8,
    CMD_PREA    = 4'd9,
    CMD_AREF    = 4'd10,
    CMD_SREF    = 4'd11,
    CMD_MRS     = 4'd12,
    CMD_EMRS    = 4'd13,
    CMD_ILLEGAL = 4'd15
  } cmd_e;

  // clocks a burst occupies: two beats per clock
  function automatic int half_beats(input logic [1:0] sel);
    case (sel)
      2'b00:   return 1;
      2'b01:   return 2;
      default: return MAX_BEATS / 2;
    endcase
  endfunction

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_mon_pkg::*;
#(
  parameter int BA_W = 2
) (
  input  logic            cke_prev,
  input  logic            cke_cur,
  input  logic            cke_hist,
  input  logic            cs_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic [BA_W-1:0] ba,
  input  logic            ap,
  output cmd_e            cmd
);

  cmd_e pin_cmd;

  always_comb begin
    case ({ras_n, cas_n, we_n})
      3'b111:  pin_cmd = CMD_NOP;
      3'b110:  pin_cmd = CMD_BSTOP;
      3'b101:  pin_cmd = ap ? CMD_RDA : CMD_RD;
      3'b100:  pin_cmd = ap ? CMD_WRA : CMD_WR;
      3'b011:  pin_cmd = CMD_ACT;
      3'b010:  pin_cmd = ap ? CMD_PREA : CMD_PRE;
      3'b001:  pin_cmd = cke_cur ? CMD_AREF : CMD_SREF;
      default: begin
        if (!ap && ba == BA_W'(0))      pin_cmd = CMD_MRS;
        else if (!ap && ba == BA_W'(1)) pin_cmd = CMD_EMRS;
        else                            pin_cmd = CMD_ILLEGAL;
      end
    endcase
  end

  always_comb begin
    if (cke_prev != cke_hist)              cmd = CMD_ILLEGAL;
    else if (cs_n)                         cmd = CMD_DESEL;
    else if (!cke_prev)                    cmd = CMD_ILLEGAL;
    else if (!cke_cur && pin_cmd != CMD_SREF) cmd = CMD_ILLEGAL;
    else                                   cmd = pin_cmd;
  end

endmodule

// File: rtl/ddr_bank_table.sv
module ddr_bank_table #(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [BA_W-1:0]      bank,
  input  logic                 open_en,
  input  logic                 close_en,
  input  logic                 close_all,
  input  logic                 ap_close,
  input  logic [BA_W-1:0]      ap_bank,
  input  logic                 flag_en,
  output logic [NUM_BANKS-1:0] active,
  output logic [NUM_BANKS-1:0] flags
);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic hit;
    logic ap_hit;
    assign hit    = (bank == BA_W'(g));
    assign ap_hit = ap_close && (ap_bank == BA_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        active[g] <= 1'b0;
        flags[g]  <= 1'b0;
      end else begin
        if (open_en && hit)
          active[g] <= 1'b1;
        else if (close_all || (close_en && hit) || ap_hit)
          active[g] <= 1'b0;
        if (flag_en && hit)
          flags[g] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/ddr_burst_track.sv
module ddr_burst_track
  import ddr_mon_pkg::*;
#(
  parameter int BA_W  = 2,
  parameter int CNT_W = $clog2(MAX_BEATS / 2 + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            start_wr,
  input  logic            start_ap,
  input  logic [BA_W-1:0] start_bank,
  input  logic [1:0]      bl_sel,
  input  logic            stop,
  output logic            busy,
  output logic            is_wr,
  output logic            ap_fire,
  output logic [BA_W-1:0] ap_bank
);

  logic [CNT_W-1:0] cnt_q;
  logic             wr_q;
  logic             ap_q;
  logic [BA_W-1:0]  bank_q;

  assign busy    = (cnt_q != '0);
  assign is_wr   = busy && wr_q;
  assign ap_fire = busy && ap_q && ((cnt_q == CNT_W'(1)) || stop);
  assign ap_bank = bank_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wr_q   <= 1'b0;
      ap_q   <= 1'b0;
      bank_q <= '0;
    end else if (start) begin
      cnt_q  <= CNT_W'(half_beats(bl_sel));
      wr_q   <= start_wr;
      ap_q   <= start_ap;
      bank_q <= start_bank;
    end else if (stop) begin
      cnt_q  <= '0;
      ap_q   <= 1'b0;
    end else if (busy) begin
      cnt_q  <= cnt_q - CNT_W'(1);
    end
  end

endmodule

// File: rtl/ddr_cmd_monitor.sv
module ddr_cmd_monitor
  import ddr_mon_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cke_prev_i,
  input  logic                 cke_cur_i,
  input  logic                 cs_n_i,
  input  logic                 ras_n_i,
  input  logic                 cas_n_i,
  input  logic                 we_n_i,
  input  logic [BA_W-1:0]      ba_i,
  input  logic                 ap_i,
  input  logic [1:0]           bl_sel_i,
  output logic [3:0]           cmd_o,
  output logic [BA_W-1:0]      bank_o,
  output logic [NUM_BANKS-1:0] bank_active_o,
  output logic                 busy_o,
  output logic                 busy_wr_o,
  output logic                 err_o,
  output logic [NUM_BANKS-1:0] bank_err_o
);

  logic            cke_hist_q;
  cmd_e            cmd_d;
  cmd_e            cmd_q;
  logic [BA_W-1:0] bank_q;
  logic            err_q;

  logic            busy;
  logic            busy_wr;
  logic            ap_fire;
  logic [BA_W-1:0] ap_bank;
  logic [NUM_BANKS-1:0] active;
  logic [NUM_BANKS-1:0] flags;

  always_ff @(posedge clk) begin
    if (!rst_n) cke_hist_q <= 1'b1;
    else        cke_hist_q <= cke_cur_i;
  end

  ddr_cmd_decode #(.BA_W(BA_W)) u_decode (
    .cke_prev (cke_prev_i),
    .cke_cur  (cke_cur_i),
    .cke_hist (cke_hist_q),
    .cs_n     (cs_n_i),
    .ras_n    (ras_n_i),
    .cas_n    (cas_n_i),
    .we_n     (we_n_i),
    .ba       (ba_i),
    .ap       (ap_i),
    .cmd      (cmd_d)
  );

  logic is_rd, is_wr_cmd, is_rw, bank_open;
  logic act_err, rw_idle_err, rw_busy_err, bst_wr_err;
  logic start, stop, open_en, err_d;

  assign is_rd       = (cmd_d == CMD_RD) || (cmd_d == CMD_RDA);
  assign is_wr_cmd   = (cmd_d == CMD_WR) || (cmd_d == CMD_WRA);
  assign is_rw       = is_rd || is_wr_cmd;
  assign bank_open   = active[ba_i];

  assign act_err     = (cmd_d == CMD_ACT) && bank_open;
  assign rw_idle_err = is_rw && !bank_open;
  assign rw_busy_err = is_rw && bank_open && busy;
  assign bst_wr_err  = (cmd_d == CMD_BSTOP) && busy_wr;

  assign open_en = (cmd_d == CMD_ACT) && !bank_open;
  assign start   = is_rw && bank_open && !busy;
  assign stop    = (cmd_d == CMD_BSTOP) && busy && !busy_wr;
  assign err_d   = (cmd_d == CMD_ILLEGAL) || act_err || rw_idle_err ||
                   rw_busy_err || bst_wr_err;

  ddr_bank_table #(.NUM_BANKS(NUM_BANKS), .BA_W(BA_W)) u_banks (
    .clk       (clk),
    .rst_n     (rst_n),
    .bank      (ba_i),
    .open_en   (open_en),
    .close_en  (cmd_d == CMD_PRE),
    .close_all (cmd_d == CMD_PREA),
    .ap_close  (ap_fire),
    .ap_bank   (ap_bank),
    .flag_en   (act_err || rw_idle_err),
    .active    (active),
    .flags     (flags)
  );

  ddr_burst_track #(.BA_W(BA_W)) u_burst (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_wr   (is_wr_cmd),
    .start_ap   ((cmd_d == CMD_RDA) || (cmd_d == CMD_WRA)),
    .start_bank (ba_i),
    .bl_sel     (bl_sel_i),
    .stop       (stop),
    .busy       (busy),
    .is_wr      (busy_wr),
    .ap_fire    (ap_fire),
    .ap_bank    (ap_bank)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= CMD_DESEL;
      bank_q <= '0;
      err_q  <= 1'b0;
    end else begin
      cmd_q <= cmd_d;
      err_q <= err_d;
      if (cmd_d != CMD_DESEL) bank_q <= ba_i;
    end
  end

  assign cmd_o         = cmd_q;
  assign bank_o        = bank_q;
  assign bank_active_o = active;
  assign busy_o        = busy;
  assign busy_wr_o     = busy_wr;
  assign err_o         = err_q;
  assign bank_err_o    = flags;

endmodule

// File: rtl/ddr_cmd_monitor_chk.sv
module ddr_cmd_monitor_chk
  import ddr_mon_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = $clog2(NUM_BANKS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cs_n_i,
  input logic                 ras_n_i,
  input logic                 cas_n_i,
  input logic                 we_n_i,
  input logic [3:0]           cmd_o,
  input logic [BA_W-1:0]      bank_o,
  input logic [NUM_BANKS-1:0] bank_active_o,
  input logic                 busy_o,
  input logic                 busy_wr_o,
  input logic                 err_o,
  input logic [NUM_BANKS-1:0] bank_err_o
);

  a_r2_desel_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_i && !busy_o) |=> $stable(bank_active_o));

  a_r2_desel_code: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_i |=> (cmd_o == CMD_DESEL || err_o));

  a_r7_illegal_err: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_ILLEGAL) |-> err_o);

  a_r9_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_ACT && !err_o) |-> bank_active_o[bank_o]);

  a_r10_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((bank_err_o & $past(bank_err_o)) == $past(bank_err_o)));

  a_r13_bst_write_err: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_i && ras_n_i && cas_n_i && !we_n_i && busy_wr_o) |=> err_o);

endmodule

bind ddr_cmd_monitor ddr_cmd_monitor_chk #(.NUM_BANKS(NUM_BANKS), .BA_W(BA_W)) u_chk (.*);

// File: tb/ddr_cmd_monitor_bench.sv
`timescale 1ns/1ps
module ddr_cmd_monitor_bench;

  localparam logic [2:0] P_NOP = 3'b111, P_BST = 3'b110, P_RD = 3'b101,
                         P_WR = 3'b100, P_ACT = 3'b011, P_PRE = 3'b010,
                         P_REF = 3'b001, P_MRS = 3'b000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke_prev = 1'b1, cke_cur = 1'b1;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = 2'd0;
  logic ap = 1'b0;
  logic [1:0] bl_sel = 2'b10;
  logic [3:0] cmd_o;
  logic [1:0] bank_o;
  logic [3:0] bank_active_o, bank_err_o;
  logic busy_o, busy_wr_o, err_o;

  int n_checks = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  ddr_cmd_monitor u_ddr_cmd_monitor (
    .clk(clk), .rst_n(rst_n), .cke_prev_i(cke_prev), .cke_cur_i(cke_cur),
    .cs_n_i(cs_n), .ras_n_i(ras_n), .cas_n_i(cas_n), .we_n_i(we_n),
    .ba_i(ba), .ap_i(ap), .bl_sel_i(bl_sel), .cmd_o(cmd_o), .bank_o(bank_o),
    .bank_active_o(bank_active_o), .busy_o(busy_o), .busy_wr_o(busy_wr_o),
    .err_o(err_o), .bank_err_o(bank_err_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic issue(input logic c, input logic [2:0] pins, input logic [1:0] b,
                       input logic a, input logic kp, input logic kc);
    @(negedge clk);
    cs_n = c; {ras_n, cas_n, we_n} = pins; ba = b; ap = a;
    cke_prev = kp; cke_cur = kc;
    @(posedge clk);
    #1;
  endtask

  task automatic cmd(input logic [2:0] pins, input logic [1:0] b, input logic a);
    issue(1'b0, pins, b, a, 1'b1, 1'b1);
  endtask

  task automatic do_reset(input logic [1:0] bl);
    @(negedge clk);
    rst_n = 1'b0; bl_sel = bl;
    cs_n = 1'b1; cke_prev = 1'b1; cke_cur = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset;
    do_reset(2'b10);
    @(posedge clk); #1;
    chk("R1 cmd", cmd_o, 0);
    chk("R1 active", bank_active_o, 0);
    chk("R1 busy", {busy_o, busy_wr_o}, 0);
    chk("R1 err", {err_o, bank_err_o}, 0);
  endtask

  task automatic t_decode;
    do_reset(2'b10);
    cmd(P_NOP, 2'd2, 1'b1);  chk("R3 nop", cmd_o, 1);  chk("R3 bank", bank_o, 2);
    cmd(P_REF, 2'd0, 1'b0);  chk("R6 aref", cmd_o, 10); chk("R6 err", err_o, 0);
    cmd(P_MRS, 2'd0, 1'b0);  chk("R5 mrs", cmd_o, 12);
    cmd(P_MRS, 2'd1, 1'b0);  chk("R5 emrs", cmd_o, 13); chk("R5 emrs err", err_o, 0);
    cmd(P_MRS, 2'd2, 1'b0);  chk("R5 bad bank", cmd_o, 15); chk("R5 bad err", err_o, 1);
    cmd(P_MRS, 2'd0, 1'b1);  chk("R5 ap high", cmd_o, 15);
    cmd(P_BST, 2'd0, 1'b0);  chk("R13 idle bst", cmd_o, 2); chk("R13 idle err", err_o, 0);
  endtask

  task automatic t_deselect;
    do_reset(2'b10);
    cmd(P_ACT, 2'd3, 1'b0);
    issue(1'b1, P_PRE, 2'd3, 1'b1, 1'b1, 1'b1);
    chk("R2 desel code", cmd_o, 0); chk("R2 desel err", err_o, 0);
    issue(1'b1, P_RD, 2'd0, 1'b0, 1'b1, 1'b1);
    chk("R2 active held", bank_active_o, 4'b1000);
    chk("R2 bank held", bank_o, 3);
    chk("R2 no busy", busy_o, 0);
  endtask

  task automatic t_banks;
    do_reset(2'b10);
    cmd(P_ACT, 2'd0, 1'b0); cmd(P_ACT, 2'd2, 1'b0); cmd(P_ACT, 2'd3, 1'b0);
    chk("R9 open", bank_active_o, 4'b1101); chk("R3 act", cmd_o, 7);
    cmd(P_PRE, 2'd2, 1'b0);
    chk("R4 pre one", bank_active_o, 4'b1001); chk("R4 pre code", cmd_o, 8);
    cmd(P_PRE, 2'd1, 1'b1);
    chk("R4 pre all", bank_active_o, 4'b0000); chk("R4 prea code", cmd_o, 9);
  endtask

  task automatic t_bank_err;
    do_reset(2'b10);
    cmd(P_ACT, 2'd1, 1'b0);
    cmd(P_ACT, 2'd1, 1'b0);
    chk("R10 act twice err", err_o, 1); chk("R10 flag", bank_err_o, 4'b0010);
    cmd(P_RD, 2'd2, 1'b0);
    chk("R10 rd idle err", err_o, 1); chk("R10 flag2", bank_err_o, 4'b0110);
    chk("R10 rd ignored", busy_o, 0); chk("R10 active kept", bank_active_o, 4'b0010);
    cmd(P_NOP, 2'd0, 1'b0);
    chk("R10 sticky", bank_err_o, 4'b0110); chk("R10 strobe", err_o, 0);
  endtask

  task automatic t_burst_plain;
    do_reset(2'b01);
    cmd(P_ACT, 2'd1, 1'b0);
    cmd(P_WR, 2'd1, 1'b0);
    chk("R4 wr code", cmd_o, 5); chk("R11 busy wr", {busy_o, busy_wr_o}, 3);
    cmd(P_RD, 2'd1, 1'b0);
    chk("R11 rd during burst err", err_o, 1); chk("R11 still wr", busy_wr_o, 1);
    cmd(P_NOP, 2'd0, 1'b0);
    chk("R11 bl4 end", busy_o, 0); chk("R11 bank still open", bank_active_o, 4'b0010);
  endtask

  task automatic t_burst_ap;
    do_reset(2'b10);
    cmd(P_ACT, 2'd1, 1'b0);
    cmd(P_RD, 2'd1, 1'b1);
    chk("R4 rda code", cmd_o, 4); chk("R11 rd busy", {busy_o, busy_wr_o}, 2);
    for (int i = 0; i < 3; i++) cmd(P_NOP, 2'd0, 1'b0);
    chk("R12 still busy", busy_o, 1); chk("R12 still open", bank_active_o, 4'b0010);
    cmd(P_NOP, 2'd0, 1'b0);
    chk("R12 done", busy_o, 0); chk("R12 closed", bank_active_o, 4'b0000);
  endtask

  task automatic t_burst_short;
    do_reset(2'b00);
    cmd(P_ACT, 2'd0, 1'b0);
    cmd(P_WR, 2'd0, 1'b1);
    chk("R4 wra code", cmd_o, 6); chk("R11 bl2 busy", busy_o, 1);
    cmd(P_NOP, 2'd0, 1'b0);
    chk("R11 bl2 end", busy_o, 0); chk("R12 wra closed", bank_active_o, 4'b0000);
  endtask

  task automatic t_bst;
    do_reset(2'b10);
    cmd(P_ACT, 2'd0, 1'b0);
    cmd(P_ACT, 2'd2, 1'b0);
    cmd(P_RD, 2'd2, 1'b1);
    cmd(P_NOP, 2'd0, 1'b0);
    cmd(P_BST, 2'd0, 1'b0);
    chk("R13 read stopped", busy_o, 0); chk("R13 no err", err_o, 0);
    chk("R13 ap applied", bank_active_o, 4'b0001);
    cmd(P_WR, 2'd0, 1'b0);
    cmd(P_BST, 2'd0, 1'b0);
    chk("R13 bst write err", err_o, 1); chk("R13 write runs", busy_wr_o, 1);
    for (int i = 0; i < 3; i++) cmd(P_NOP, 2'd0, 1'b0);
    chk("R13 write ends", busy_o, 0);
  endtask

  task automatic t_cke;
    do_reset(2'b10);
    issue(1'b0, P_REF, 2'd0, 1'b0, 1'b1, 1'b0);
    chk("R6 sref", cmd_o, 11); chk("R6 sref err", err_o, 0);
    issue(1'b1, P_NOP, 2'd0, 1'b0, 1'b0, 1'b0);
    chk("R8 low held", cmd_o, 0); chk("R8 low ok", err_o, 0);
    issue(1'b1, P_NOP, 2'd0, 1'b0, 1'b0, 1'b1);
    issue(1'b0, P_NOP, 2'd0, 1'b0, 1'b1, 1'b1);
    chk("R8 resumed", cmd_o, 1); chk("R8 resumed err", err_o, 0);
    issue(1'b0, P_NOP, 2'd0, 1'b0, 1'b0, 1'b1);
    chk("R8 glitch", cmd_o, 15); chk("R8 glitch err", err_o, 1);
    issue(1'b0, P_NOP, 2'd0, 1'b0, 1'b1, 1'b0);
    chk("R7 cke_cur low nop", cmd_o, 15);
    issue(1'b0, P_NOP, 2'd0, 1'b0, 1'b0, 1'b0);
    chk("R7 cke_prev low", cmd_o, 15); chk("R7 err", err_o, 1);
    issue(1'b1, P_NOP, 2'd0, 1'b0, 1'b0, 1'b1);
    issue(1'b0, P_ACT, 2'd1, 1'b0, 1'b1, 1'b1);
    chk("R7 recovered", err_o, 0); chk("R9 after cke", bank_active_o, 4'b0010);
  endtask

  initial begin
    t_reset();
    t_decode();
    t_deselect();
    t_banks();
    t_bank_err();
    t_burst_plain();
    t_burst_ap();
    t_burst_short();
    t_bst();
    t_cke();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule